// File: doc/BRIEF.md
# Run-Length Stream Expander

This block rebuilds a sample stream from a run-length-coded word stream, such as the contents of a compressed capture buffer read back after a capture. Each 32-bit input word is either a fresh 31-bit sample or a count of further repeats of the most recent sample. The block emits one 31-bit sample per output beat. A flag on the output marks the beat that carries a freshly received sample.

Both sides use a valid/ready handshake. Once a sample is pending on the output, the input is not accepted until the last beat of that literal or run has been taken. Malformed words set a sticky protocol-error output and are discarded without producing samples. A synchronous reset returns the block to its empty state.

Top module: `rle_expander`

## Requirements
- R1: Input bit 31 is the type flag (0 = literal sample, 1 = repeat count). Bits 30:0 are the payload. A well-formed stream never raises `protoErr`.
- R2: An accepted literal is emitted exactly once, with `outFirst` = 1 and `outSample` equal to its payload, and it becomes the stored value.
- R3: An accepted count N (1 ≤ N) emits the stored value N further times, with `outFirst` = 0 on each of those beats.
- R4: A count word whose payload is 0 sets `protoErr` and produces no samples.
- R5: A count word accepted before any literal since reset sets `protoErr` and produces no samples.
- R6: A count word that directly follows an accepted count word sets `protoErr` and is ignored. Only the first count is replayed.
- R7: The all-ones count 0x7FFFFFFF is a legal run length. It does not wrap, and it keeps the output valid and error-free for as long as it is replayed.
- R8: While an output beat is pending, `inReady` is 0. When `outReady` is low, `outSample` and `outFirst` hold and the remaining repeat count does not advance.
- R9: Once set, `protoErr` stays high until reset.
- R10: While `rst` is high, the block clears `outValid`, `outFirst`, `outSample`, `protoErr`, the remaining count and the record of having seen a literal. A count arriving after reset therefore raises R5's error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inWord | input | 32 | Coded word: bit 31 type, bits 30:0 payload |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Downstream accepts the sample |
| outSample | output | 31 | Expanded sample value |
| outFirst | output | 1 | High on the beat that carries a new literal |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
A wrong remaining count shows at the ports within one run. The block emits too many or too few beats before `inReady` rises again, so the next literal arrives in the wrong position of the expanded stream. A stale or corrupted stored value appears on the very next replayed beat as a sample that differs from the preceding literal. A lost "seen literal" or "last was a count" bit shows in the cycle after the offending word, either as `protoErr` failing to rise or as spurious replayed beats. Comparing the stream beat by beat under random backpressure exposes each of these within a few cycles of the fault.

// File: rtl/rle_pkg.sv
package rle_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic takeLit;  // accept a literal word
    logic takeRun;  // accept a well-formed count word
    logic beat;     // output handshake this cycle
  } rle_ctrl_t;
endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inFlag,
  input  logic      payloadZero,
  input  logic      outReady,
  input  logic      cntZero,
  output logic      inReady,
  output logic      outValid,
  output logic      outFirst,
  output logic      protoErr,
  output rle_ctrl_t ctrl
);
  logic validQ, firstQ, seenLit, lastRun, errQ;
  logic accept, badRun, lastBeat;

  always_comb begin
    accept       = inValid && !validQ;
    badRun       = accept && inFlag && (!seenLit || lastRun || payloadZero);
    ctrl.takeLit = accept && !inFlag;
    ctrl.takeRun = accept && inFlag && !badRun;
    ctrl.beat    = validQ && outReady;
    lastBeat     = ctrl.beat && cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ  <= 1'b0;
      firstQ  <= 1'b0;
      seenLit <= 1'b0;
      lastRun <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (ctrl.takeLit || ctrl.takeRun) validQ <= 1'b1;
      else if (lastBeat)                validQ <= 1'b0;

      if (ctrl.takeLit)                 firstQ <= 1'b1;
      else if (ctrl.takeRun || lastBeat) firstQ <= 1'b0;

      if (ctrl.takeLit) seenLit <= 1'b1;

      if (ctrl.takeLit)      lastRun <= 1'b0;
      else if (ctrl.takeRun) lastRun <= 1'b1;

      if (badRun) errQ <= 1'b1;
    end
  end

  assign inReady  = !validQ;
  assign outValid = validQ;
  assign outFirst = firstQ;
  assign protoErr = errQ;
endmodule

// File: rtl/rle_dp.sv
module rle_dp
  import rle_pkg::*;
#(
  parameter int PAY_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PAY_W-1:0] payload,
  input  rle_ctrl_t        ctrl,
  output logic [PAY_W-1:0] outSample,
  output logic             cntZero
);
  logic [PAY_W-1:0] curVal;
  logic [PAY_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      curVal <= '0;
      remain <= '0;
    end else begin
      if (ctrl.takeLit) curVal <= payload;

      if (ctrl.takeLit)               remain <= '0;
      else if (ctrl.takeRun)          remain <= payload - 1'b1;
      else if (ctrl.beat && !cntZero) remain <= remain - 1'b1;
    end
  end

  assign cntZero   = (remain == '0);
  assign outSample = curVal;
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int PAY_W = WORD_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic             outValid,
  input  logic             outReady,
  output logic [PAY_W-1:0] outSample,
  output logic             outFirst,
  output logic             protoErr
);
  rle_ctrl_t ctrl;
  logic      cntZero;
  logic      inFlag;
  logic      payloadZero;

  assign inFlag      = inWord[WORD_W-1];
  assign payloadZero = (inWord[PAY_W-1:0] == '0);

  rle_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inFlag     (inFlag),
    .payloadZero(payloadZero),
    .outReady   (outReady),
    .cntZero    (cntZero),
    .inReady    (inReady),
    .outValid   (outValid),
    .outFirst   (outFirst),
    .protoErr   (protoErr),
    .ctrl       (ctrl)
  );

  rle_dp #(.PAY_W(PAY_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .payload  (inWord[PAY_W-1:0]),
    .ctrl     (ctrl),
    .outSample(outSample),
    .cntZero  (cntZero)
  );
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
  parameter int WORD_W = 32,
  localparam int PAY_W = WORD_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [WORD_W-1:0] inWord,
  input logic              outValid,
  input logic              outReady,
  input logic [PAY_W-1:0]  outSample,
  input logic              outFirst,
  input logic              protoErr
);
  logic             seenLitC = 1'b0;
  logic             pastRst  = 1'b0;
  logic [PAY_W-1:0] lastLitC = '0;
  logic             accLit, accRun;

  assign accLit = inValid && inReady && !inWord[WORD_W-1];
  assign accRun = inValid && inReady &&  inWord[WORD_W-1];

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (rst) begin
      seenLitC <= 1'b0;
      lastLitC <= '0;
    end else if (accLit) begin
      seenLitC <= 1'b1;
      lastLitC <= inWord[PAY_W-1:0];
    end
  end

  // R10: the cycle after a reset cycle shows the cleared state
  always_ff @(posedge clk) begin
    if (pastRst) begin
      a_reset_state_r10: assert (!outValid && !protoErr && !outFirst && outSample == '0);
    end
  end

  p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outSample) && $stable(outFirst)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);

  p_lit_once_r2: assert property (@(posedge clk) disable iff (rst)
    accLit |=> (outValid && outFirst && outSample == $past(inWord[PAY_W-1:0])));

  p_run_before_lit_r5: assert property (@(posedge clk) disable iff (rst)
    (accRun && !seenLitC) |=> (protoErr && !outValid));

  p_zero_count_r4: assert property (@(posedge clk) disable iff (rst)
    (accRun && inWord[PAY_W-1:0] == '0) |=> (protoErr && !outValid));

  p_replay_value_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outFirst) |-> (outSample == lastLitC));
endmodule

bind rle_expander rle_expander_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inWord   (inWord),
  .outValid (outValid),
  .outReady (outReady),
  .outSample(outSample),
  .outFirst (outFirst),
  .protoErr (protoErr)
);

// File: tb/test_rle_expander.sv
module test_rle_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [30:0] outSample;
  logic        outFirst;
  logic        protoErr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit monEn = 1'b1;
  bit hold  = 1'b0;
  logic [30:0] modelVal = '0;
  logic [31:0] expQ[$];

  localparam int NVEC = 12;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0005, 32'h8000_0003, 32'h7FFF_FFFF, 32'h0000_0000,
    32'h8000_0001, 32'h1234_5678, 32'h8000_0002, 32'h0000_0001,
    32'h0000_0001, 32'h8000_0004, 32'h5555_5555, 32'h8000_0001
  };

  always #10 clk = ~clk;

  rle_expander i_rle_expander (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outSample(outSample),
    .outFirst(outFirst), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference expansion of a well-formed word (R1, R2, R3)
  task automatic model(input logic [31:0] w);
    if (!w[31]) begin
      modelVal = w[30:0];
      expQ.push_back({1'b1, w[30:0]});
    end else begin
      for (int k = 0; k < int'(w[30:0]); k++) expQ.push_back({1'b0, modelVal});
    end
  endtask

  task automatic send(input logic [31:0] w, input int gap);
    repeat (gap) @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expQ.delete();
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expQ.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !outValid, req, {31'd0, outValid}, 32'd0);
  endtask

  // output side: random backpressure and beat-by-beat comparison
  initial begin
    forever begin
      @(negedge clk);
      outReady = !monEn ? 1'b1 : (hold ? 1'b0 : (($urandom % 4) != 0));
      if (monEn && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R3 extra beat", {outFirst, outSample}, 32'hxxxx_xxxx);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check({outFirst, outSample} === e, "R2/R3 stream", {outFirst, outSample}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!outValid && !protoErr && !outFirst && outSample == 0 && inReady,
          "R10 reset state", {outValid, protoErr, outFirst, outSample[28:0]}, 32'd0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      model(VEC[i]);
      send(VEC[i], i % 3);
    end
    drain("R2/R3 table drained");
    check(!protoErr, "R1 no error on table", {31'd0, protoErr}, 32'd0);

    // random streams, never two counts in a row
    for (int g = 0; g < 60; g++) begin
      logic [31:0] w;
      w = {1'b0, 31'($urandom)};
      if (g % 5 == 0) w = {1'b0, modelVal};
      model(w);
      send(w, $urandom % 3);
      if ($urandom % 3 != 0) begin
        w = {1'b1, 31'(1 + $urandom % 6)};
        model(w);
        send(w, $urandom % 3);
      end
    end
    drain("R3 random drained");
    check(!protoErr, "R1 no error on random", {31'd0, protoErr}, 32'd0);

    // R8: backpressure holds output and input
    hold = 1'b1;
    model(32'h0000_0ABC); send(32'h0000_0ABC, 0);
    model(32'h8000_0003);
    inValid = 1'b1; inWord = 32'h8000_0003;
    repeat (5) @(negedge clk);
    check(!inReady && outValid && outFirst && outSample == 31'h0ABC, "R8 held",
          {inReady, outFirst, outSample[29:0]}, {2'b01, 30'h0ABC});
    hold = 1'b0;
    while (!inReady) @(negedge clk);
    @(negedge clk); inValid = 1'b0;
    drain("R8 released");

    // R5: count before any literal
    doReset();
    send(32'h8000_0003, 0);
    repeat (3) @(negedge clk);
    check(protoErr && !outValid, "R5 count before literal", {outValid, protoErr}, 32'd1);

    // R4: zero count
    doReset();
    model(32'h0000_0009); send(32'h0000_0009, 0);
    send(32'h8000_0000, 0);
    drain("R4 zero count no beats");
    check(protoErr, "R4 zero count error", {31'd0, protoErr}, 32'd1);

    // R6: back-to-back counts, R9 sticky
    doReset();
    model(32'h0000_0007); send(32'h0000_0007, 0);
    model(32'h8000_0002); send(32'h8000_0002, 0);
    send(32'h8000_0005, 0);
    drain("R6 second count ignored");
    check(protoErr, "R6 error raised", {31'd0, protoErr}, 32'd1);
    model(32'h0000_0011); send(32'h0000_0011, 1);
    drain("R9 stream continues");
    check(protoErr, "R9 error sticky", {31'd0, protoErr}, 32'd1);

    // R7: maximum count replays without wrap
    doReset();
    monEn = 1'b0;
    send(32'h0000_0042, 0);
    send(32'hFFFF_FFFF, 0);
    begin
      int miss = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (!outValid || outFirst || outSample != 31'h42 || protoErr || inReady) miss++;
      end
      check(miss == 0, "R7 max count", miss, 0);
    end

    // R10: reset mid-run clears state and the seen-literal record
    doReset();
    @(negedge clk);
    check(!outValid && !protoErr && !outFirst && outSample == 0, "R10 reset mid-run",
          {outValid, protoErr, outFirst, outSample[28:0]}, 32'd0);
    send(32'h8000_0001, 0);
    repeat (2) @(negedge clk);
    check(protoErr && !outValid, "R10 seen-literal cleared", {outValid, protoErr}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule